// File: doc/BRIEF.md
# Flash Modify Permission Guard

This block stands between a processor's peripheral bus and a flash controller. It decides whether the next flash modify operation may proceed; a modify operation is a block erase, a sector erase or a single-word program. Software arms the guard by writing two key bytes to a write-only key register, FAh first and then F5h. Only after that does the guard raise a permission flag. The permission covers exactly one operation. The flash controller sends a start pulse when it begins an operation, and that pulse uses up the permission. If the pulse arrives while no permission is held, the guard blocks the operation and answers with a one-cycle reject pulse.

Bus traffic to other addresses between the two keys is harmless. A wrong byte written to the key register cancels the arming. The block also holds a 3-bit segment register, which software can read and write and which selects the flash segment being modified.

Bus writes are plain strobes, with no valid/ready handshake. The guard accepts every write in the cycle it appears and never stalls the bus. Reads are combinational from the read address. There is no back-pressure anywhere in the block.

Top module: `flash_unlock_guard`

## Requirements
- R1: After a synchronous active-low reset, the permission flag and the reject pulse are 0, and the segment register is 0.
- R2: A key-register write of FAh followed by a key-register write of F5h sets the permission flag on the clock edge that takes the F5h write. The flag is visible one cycle after F5h is presented.
- R3: A start pulse while the permission flag is set clears the flag on that edge and raises no reject. The permission serves one operation only.
- R4: Writes to other addresses, and idle cycles, between the FAh and F5h key writes do not cancel the first step.
- R5: After FAh, a key write of any value other than FAh or F5h returns the guard to idle. A later F5h alone then does not grant permission.
- R6: A key write of F5h from idle has no effect. A repeated FAh keeps the guard in the first-step state.
- R7: A start pulse while the permission flag is clear raises the reject output for exactly one cycle, on the following cycle. The guard's key state is not changed by it.
- R8: While permission is held, a key write of FAh drops the permission and re-arms the first step. Any other key value drops the permission and returns the guard to idle.
- R9: A write to the segment address stores data bits 2..0. Reading the segment address returns the segment in bits 2..0 with bits 7..3 zero. Reading the key address returns 00h. With default parameters the key address is E6h and the segment address is E8h.
- R10: When a start pulse and a key write fall in the same cycle, the guard applies the start pulse first (consume or reject) and then applies the key write to the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data |
| rd_addr | input | ADDR_W | Bus read address |
| rd_data | output | 8 | Combinational read data |
| op_start | input | 1 | Pulse from the flash controller as a modify operation begins |
| mod_enable | output | 1 | Permission for one modify operation |
| op_reject | output | 1 | One-cycle pulse for a blocked operation |
| seg_addr | output | 3 | Current flash segment |

## Verification
Two events can fall in the same clock cycle: an operation start pulse from the flash controller, and a key-register write from the bus. The guard resolves them by a fixed rule, consume or reject first and the key write second.

Directed cases drive this overlap from each guard state with FAh, F5h and other key bytes. A later F5h write then shows whether the first step survived. The random phase draws the start pulse and key-register writes independently, so the two overlap often. A bench function models the two-step rule and judges every cycle's permission flag, reject pulse and segment readback.

// File: rtl/fguard_pkg.sv
package fguard_pkg;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hFA;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'hF5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_KEY1 = 2'd1,
    ST_OPEN = 2'd2
  } guard_state_t;
endpackage

// File: rtl/fg_key_fsm.sv
module fg_key_fsm
  import fguard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              op_start,
  output logic              mod_enable,
  output logic              op_reject
);
  guard_state_t state_q, base_s, state_d;

  // start pulse is resolved first, key write then applies to the result
  always_comb begin
    base_s  = (op_start && state_q == ST_OPEN) ? ST_IDLE : state_q;
    state_d = base_s;
    if (key_wr) begin
      unique case (base_s)
        ST_IDLE: state_d = (key_data == KEY_FIRST) ? ST_KEY1 : ST_IDLE;
        ST_KEY1: begin
          if (key_data == KEY_FIRST)       state_d = ST_KEY1;
          else if (key_data == KEY_SECOND) state_d = ST_OPEN;
          else                             state_d = ST_IDLE;
        end
        ST_OPEN: state_d = (key_data == KEY_FIRST) ? ST_KEY1 : ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_reject <= 1'b0;
    end else begin
      state_q   <= state_d;
      op_reject <= op_start && (state_q != ST_OPEN);
    end
  end

  assign mod_enable = (state_q == ST_OPEN);

  // R2
  second_key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_KEY1 && key_wr && key_data == KEY_SECOND) |=> mod_enable);

  // R3
  single_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_enable && op_start) |=> (!mod_enable && !op_reject));

  // R4
  key1_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_KEY1 && !key_wr) |=> (state_q == ST_KEY1));

  // R5
  wrong_key_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_KEY1 && key_wr && key_data != KEY_FIRST && key_data != KEY_SECOND)
    |=> (state_q == ST_IDLE));

  // R7
  reject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !mod_enable) |=> op_reject);

  // R7
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_reject |-> ($past(op_start) && !$past(mod_enable)));

  // R8
  open_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_enable && !key_wr && !op_start) |=> mod_enable);
endmodule

// File: rtl/fg_seg_reg.sv
module fg_seg_reg
  import fguard_pkg::*;
#(
  parameter int SEG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEG_W-1:0]  seg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      seg_q <= '0;
    else if (seg_wr) seg_q <= wr_data[SEG_W-1:0];
  end

  // R9
  seg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr |=> (seg_q == $past(wr_data[SEG_W-1:0])));

  // R9
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_wr |=> $stable(seg_q));
endmodule

// File: rtl/flash_unlock_guard.sv
module flash_unlock_guard
  import fguard_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                SEG_W    = 3,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hE6,
  parameter logic [ADDR_W-1:0] SEG_ADDR = 8'hE8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              op_start,
  output logic              mod_enable,
  output logic              op_reject,
  output logic [SEG_W-1:0]  seg_addr
);
  localparam int PAD_W = DATA_W - SEG_W;

  logic key_wr, seg_wr;
  logic [SEG_W-1:0] seg_q;

  assign key_wr = wr_en && (wr_addr == KEY_ADDR);
  assign seg_wr = wr_en && (wr_addr == SEG_ADDR);

  fg_key_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_wr     (key_wr),
    .key_data   (wr_data),
    .op_start   (op_start),
    .mod_enable (mod_enable),
    .op_reject  (op_reject)
  );

  fg_seg_reg #(.SEG_W(SEG_W)) u_seg (
    .clk     (clk),
    .rst_n   (rst_n),
    .seg_wr  (seg_wr),
    .wr_data (wr_data),
    .seg_q   (seg_q)
  );

  // key register is write-only: its address reads as zero
  always_comb begin
    if (rd_addr == SEG_ADDR) rd_data = {{PAD_W{1'b0}}, seg_q};
    else                     rd_data = '0;
  end

  assign seg_addr = seg_q;

  // R9
  key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == KEY_ADDR) |-> (rd_data == '0));
endmodule

// File: tb/flash_unlock_guard_bench.sv
module flash_unlock_guard_bench;
  localparam logic [7:0] KA = 8'hE6, SA = 8'hE8, OA = 8'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, op_start = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = SA, rd_data;
  logic mod_enable, op_reject;
  logic [2:0] seg_addr;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  flash_unlock_guard u_flash_unlock_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .op_start(op_start),
    .mod_enable(mod_enable), .op_reject(op_reject), .seg_addr(seg_addr));

  function automatic void check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // model of the two-step rule: 0 idle, 1 first key seen, 2 open
  function automatic int model_next(int st, bit op, bit kw, logic [7:0] d);
    int b = (op && st == 2) ? 0 : st;
    if (!kw) return b;
    if (d == 8'hFA) return 1;
    if (b == 1 && d == 8'hF5) return 2;
    return 0;
  endfunction

  task automatic cyc(bit we, logic [7:0] a, logic [7:0] d, bit op);
    wr_en = we; wr_addr = a; wr_data = d; op_start = op;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; op_start = 1'b0;
  endtask

  task automatic outs(string tag, bit en, bit rej);
    check({tag, " enable"}, mod_enable, en);
    check({tag, " reject"}, op_reject, rej);
  endtask

  initial begin
    int st, wd;
    bit rej_exp;
    logic [2:0] seg_exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    outs("R1", 0, 0); check("R1 seg", seg_addr, 0); check("R1 read", rd_data, 0);
    // R6: F5 from idle does nothing, FA twice stays armed
    cyc(1, KA, 8'hF5, 0); outs("R6", 0, 0);
    cyc(1, KA, 8'hFA, 0); cyc(1, KA, 8'hFA, 0); outs("R6", 0, 0);
    cyc(1, KA, 8'hF5, 0); outs("R2 R6", 1, 0);
    // R3: single use
    cyc(0, OA, 0, 1); outs("R3", 0, 0);
    cyc(0, OA, 0, 1); outs("R7", 0, 1);
    cyc(0, OA, 0, 0); outs("R7 pulse end", 0, 0);
    // R4 and R9: traffic between keys
    cyc(1, KA, 8'hFA, 0);
    cyc(1, SA, 8'h05, 0); check("R9 seg", seg_addr, 5); check("R9 read", rd_data, 5);
    cyc(1, OA, 8'h33, 0); cyc(0, OA, 0, 0);
    cyc(1, KA, 8'hF5, 0); outs("R4", 1, 0);
    cyc(1, SA, 8'hFF, 0); check("R9 mask", rd_data, 8'h07);
    rd_addr = KA; #1 check("R9 key read", rd_data, 0); rd_addr = SA;
    // R8
    cyc(1, KA, 8'h12, 0); outs("R8 other", 0, 0);
    cyc(1, KA, 8'hF5, 0); outs("R8 idle", 0, 0);
    cyc(1, KA, 8'hFA, 0); cyc(1, KA, 8'hF5, 0); outs("R2", 1, 0);
    cyc(1, KA, 8'hFA, 0); outs("R8 rearm", 0, 0);
    cyc(1, KA, 8'hF5, 0); outs("R8 rearm", 1, 0);
    cyc(0, OA, 0, 1);
    // R5
    cyc(1, KA, 8'hFA, 0); cyc(1, KA, 8'h33, 0); cyc(1, KA, 8'hF5, 0); outs("R5", 0, 0);
    // R7: reject leaves first step intact
    cyc(1, KA, 8'hFA, 0); cyc(0, OA, 0, 1); outs("R7", 0, 1);
    cyc(1, KA, 8'hF5, 0); outs("R7 kept", 1, 0);
    // R10
    cyc(1, KA, 8'hFA, 1); outs("R10 consume+FA", 0, 0);
    cyc(1, KA, 8'hF5, 0); outs("R10 FA kept", 1, 0);
    cyc(1, KA, 8'hF5, 1); outs("R10 consume+F5", 0, 0);
    cyc(1, KA, 8'hF5, 0); outs("R10 idle", 0, 0);
    cyc(1, KA, 8'hFA, 1); outs("R10 reject+FA", 0, 1);
    cyc(1, KA, 8'hF5, 0); outs("R10 armed", 1, 0);

    // random phase against the model
    rst_n = 1'b0; cyc(0, OA, 0, 0); rst_n = 1'b1;
    void'($urandom(32'h5eed_1234));
    st = 0; seg_exp = 0;
    for (int i = 0; i < 3000; i++) begin
      bit we = ($urandom % 3) != 0;
      bit op = ($urandom % 4) == 0;
      int pa = $urandom % 4;
      int pd = $urandom % 5;
      logic [7:0] a = (pa < 2) ? KA : (pa == 2) ? SA : OA;
      logic [7:0] d = (pd < 2) ? 8'hFA : (pd < 4) ? 8'hF5 : 8'($urandom);
      rej_exp = op && st != 2;
      st = model_next(st, op, we && a == KA, d);
      if (we && a == SA) seg_exp = d[2:0];
      cyc(we, a, d, op);
      if (op && we && a == KA) outs("R10 rand", st == 2, rej_exp);
      else                     outs("R2 rand", st == 2, rej_exp);
      check("R9 rand", rd_data, {5'b0, seg_exp});
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule